// File: doc/BRIEF.md
# Program/Erase Pulse Sequencer

This block runs a program or block-erase operation once the command interface has started it. It drives a pulse to the array control for a fixed number of clock cycles, then spends one cycle sampling a verify input. If verify passes, the operation ends. If it fails, another pulse follows, until a per-operation pulse limit is reached and an error flag is raised. The supply-OK input is sampled when a start request arrives, and a low supply aborts the request before any pulse is driven.

During an erase, a suspend request is held until the current pulse has finished and been verified. The sequencer then parks with ready high and the suspended flag high. A resume request continues with the next pulse. The pulse count and the target address are kept across the pause, so the limit applies to the total number of erase pulses. The error flags stay set until the command interface pulses a clear input. The real durations of about 9 µs per program and about 1 s per erase are expressed here as a pulse width in cycles and a number of pulses, all set by parameters.

Top module: `pe_sequencer`

## Requirements
- R1: After reset, `ready` is 1, `pulse_on` is 0, and `susp_flag`, `erase_err`, `prog_err` and `vpp_low` are all 0.
- R2: A start while idle with `vpp_ok`=1 latches `addr_in` onto `op_addr`. It drops `ready` on the next cycle and drives `pulse_on` high for `PULSE_W` cycles. `pulse_erase` is 1 for an erase and 0 for a program. `pulse_on` is never 1 while `ready` is 1.
- R3: A start while idle with `vpp_ok`=0 sets `vpp_low`, drives no pulse and leaves `ready` at 1.
- R4: Each pulse is followed by one verify cycle. If `verify_ok` is 1 in that cycle, the operation ends with `ready`=1 and no error flag set.
- R5: If an erase has applied `MAX_ERASE` pulses and none of them verified, the erase ends with `erase_err`=1.
- R6: If a program has applied `MAX_PROG` pulses and none of them verified, the program ends with `prog_err`=1.
- R7: A `suspend_req` during an erase takes effect only after the current pulse and its verify cycle. The sequencer then holds with `ready`=1 and `susp_flag`=1, and drives no pulse.
- R8: `resume_req` while suspended restarts pulsing with the same address. Pulses already applied count toward `MAX_ERASE`.
- R9: `susp_flag` is 0 whenever the sequencer is pulsing, verifying or idle.
- R10: `start_prog` and `start_erase` have no effect while busy or suspended. `op_addr` and `pulse_erase` stay unchanged.
- R11: `erase_err`, `prog_err` and `vpp_low` stay set until `clear_status` is 1. A set in the same cycle as a clear wins.
- R12: `suspend_req` has no effect during a program or while idle.
- R13: If both start inputs are 1 in the same idle cycle, the program is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_prog | input | 1 | Start a program operation |
| start_erase | input | 1 | Start a block erase |
| addr_in | input | AW | Target address sampled on start |
| vpp_ok | input | 1 | Programming supply above minimum |
| suspend_req | input | 1 | Request to pause an erase |
| resume_req | input | 1 | Request to continue a paused erase |
| clear_status | input | 1 | Clear the sticky flags |
| verify_ok | input | 1 | Array verify result |
| pulse_on | output | 1 | High-voltage pulse enable |
| pulse_erase | output | 1 | 1 = erase pulse, 0 = program pulse |
| op_addr | output | AW | Address of the current operation |
| ready | output | 1 | 1 = idle or suspended, 0 = busy |
| susp_flag | output | 1 | Erase is parked |
| erase_err | output | 1 | Erase failed to verify (sticky) |
| prog_err | output | 1 | Program failed to verify (sticky) |
| vpp_low | output | 1 | Start refused for low supply (sticky) |

## Verification
The bench asserts suspend in the middle of a pulse. A design that stops at once would show a truncated pulse count at the moment of the pause. One that drops the pulse count on resume would apply more than `MAX_ERASE` pulses before reporting the erase error. The bench also sends start requests while the sequencer is busy and while it is suspended. A design that accepts them would change `op_addr` or the pulse type. The remaining cases are a low supply at start, suspend during a program, and flags that must survive idle cycles until cleared. A design that mishandles any of these would diverge from the reference model on the affected flag.

// File: rtl/pe_sequencer.sv
module pe_sequencer #(
  parameter int AW        = 8,
  parameter int PULSE_W   = 4,
  parameter int MAX_ERASE = 6,
  parameter int MAX_PROG  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_prog,
  input  logic          start_erase,
  input  logic [AW-1:0] addr_in,
  input  logic          vpp_ok,
  input  logic          suspend_req,
  input  logic          resume_req,
  input  logic          clear_status,
  input  logic          verify_ok,
  output logic          pulse_on,
  output logic          pulse_erase,
  output logic [AW-1:0] op_addr,
  output logic          ready,
  output logic          susp_flag,
  output logic          erase_err,
  output logic          prog_err,
  output logic          vpp_low
);
  localparam int MAXP = (MAX_ERASE > MAX_PROG) ? MAX_ERASE : MAX_PROG;
  localparam int TW   = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;
  localparam int NW   = $clog2(MAXP + 1);

  typedef enum logic [1:0] {S_IDLE, S_PULSE, S_CHECK, S_HOLD} st_t;

  st_t           st;
  logic [TW-1:0] tcnt;
  logic [NW-1:0] npulse;
  logic          pend;

  logic [NW-1:0] lim;
  logic          start_any, at_limit, fail_end;

  assign lim       = pulse_erase ? NW'(MAX_ERASE) : NW'(MAX_PROG);
  assign start_any = (st == S_IDLE) && (start_prog || start_erase);
  assign at_limit  = (npulse == lim);
  assign fail_end  = (st == S_CHECK) && !verify_ok && at_limit;

  assign pulse_on  = (st == S_PULSE);
  assign ready     = (st == S_IDLE) || (st == S_HOLD);
  assign susp_flag = (st == S_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      tcnt        <= '0;
      npulse      <= '0;
      pend        <= 1'b0;
      pulse_erase <= 1'b0;
      op_addr     <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_any) begin
          pulse_erase <= !start_prog;
          op_addr     <= addr_in;
          tcnt        <= '0;
          npulse      <= '0;
          pend        <= 1'b0;
          if (vpp_ok) st <= S_PULSE;
        end
        S_PULSE: begin
          if (suspend_req && pulse_erase) pend <= 1'b1;
          if (tcnt == TW'(PULSE_W - 1)) begin
            tcnt   <= '0;
            npulse <= npulse + 1'b1;
            st     <= S_CHECK;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_CHECK: begin
          pend <= 1'b0;
          if (verify_ok || at_limit)                     st <= S_IDLE;
          else if (pulse_erase && (pend || suspend_req)) st <= S_HOLD;
          else                                           st <= S_PULSE;
        end
        S_HOLD: if (resume_req) st <= S_PULSE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      erase_err <= 1'b0;
      prog_err  <= 1'b0;
      vpp_low   <= 1'b0;
    end else begin
      erase_err <= (erase_err && !clear_status) || (fail_end && pulse_erase);
      prog_err  <= (prog_err  && !clear_status) || (fail_end && !pulse_erase);
      vpp_low   <= (vpp_low   && !clear_status) || (start_any && !vpp_ok);
    end
  end
endmodule

// File: rtl/pe_sequencer_chk.sv
module pe_sequencer_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_prog,
  input logic          start_erase,
  input logic          vpp_ok,
  input logic          clear_status,
  input logic          pulse_on,
  input logic          pulse_erase,
  input logic [AW-1:0] op_addr,
  input logic          ready,
  input logic          susp_flag,
  input logic          erase_err,
  input logic          prog_err,
  input logic          vpp_low
);
  AST_PULSE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_on |-> !ready);  // R2
  AST_VPP_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !susp_flag && (start_prog || start_erase) && !vpp_ok) |=> (vpp_low && ready && !pulse_on));  // R3
  AST_HOLD_IDLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    susp_flag |-> (ready && !pulse_on));  // R7
  AST_BUSY_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready || susp_flag) |=> ($stable(op_addr) && $stable(pulse_erase)));  // R10
  AST_EERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_err && !clear_status) |=> erase_err);  // R11
  AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_err && !clear_status) |=> prog_err);  // R11
  AST_PROG_NO_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !pulse_erase) |=> !susp_flag);  // R12
endmodule

bind pe_sequencer pe_sequencer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
  .vpp_ok(vpp_ok), .clear_status(clear_status), .pulse_on(pulse_on),
  .pulse_erase(pulse_erase), .op_addr(op_addr), .ready(ready),
  .susp_flag(susp_flag), .erase_err(erase_err), .prog_err(prog_err),
  .vpp_low(vpp_low)
);

// File: tb/pe_sequencer_tb.sv
`timescale 1ns/1ps
module pe_sequencer_tb;
  localparam int AW = 8, PW = 4, ME = 6, MP = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_prog = 0, start_erase = 0, vpp_ok = 1, suspend_req = 0;
  logic resume_req = 0, clear_status = 0;
  logic [AW-1:0] addr_in = '0;
  logic verify_ok;
  logic pulse_on, pulse_erase, ready, susp_flag, erase_err, prog_err, vpp_low;
  logic [AW-1:0] op_addr;

  int checks = 0, errors = 0;
  int on_cnt = 0, base = 0, need = 1;

  always #10 clk = ~clk;

  pe_sequencer #(.AW(AW), .PULSE_W(PW), .MAX_ERASE(ME), .MAX_PROG(MP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
    .addr_in(addr_in), .vpp_ok(vpp_ok), .suspend_req(suspend_req),
    .resume_req(resume_req), .clear_status(clear_status), .verify_ok(verify_ok),
    .pulse_on(pulse_on), .pulse_erase(pulse_erase), .op_addr(op_addr),
    .ready(ready), .susp_flag(susp_flag), .erase_err(erase_err),
    .prog_err(prog_err), .vpp_low(vpp_low));

  // behavioural verify stub: passes once `need` full pulses were applied
  assign verify_ok = ((on_cnt - base) >= need * PW);
  always @(posedge clk) if (pulse_on) on_cnt <= on_cnt + 1;

  // reference model: 0 idle, 1 pulsing, 2 verifying, 3 parked
  int m_st = 0, m_t = 0, m_n = 0;
  bit m_pend = 0, m_er = 0, m_ee = 0, m_pe = 0, m_vl = 0;
  logic [AW-1:0] m_addr = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st <= 0; m_t <= 0; m_n <= 0; m_pend <= 0; m_er <= 0; m_addr <= '0;
      m_ee <= 0; m_pe <= 0; m_vl <= 0;
    end else begin
      bit se, sp, sv;
      se = 0; sp = 0; sv = 0;
      if (m_st == 0 && (start_prog || start_erase)) begin
        m_er <= !start_prog; m_addr <= addr_in; m_t <= 0; m_n <= 0; m_pend <= 0;
        if (vpp_ok) m_st <= 1; else sv = 1;
      end else if (m_st == 1) begin
        if (suspend_req && m_er) m_pend <= 1;
        if (m_t + 1 == PW) begin m_t <= 0; m_n <= m_n + 1; m_st <= 2; end
        else m_t <= m_t + 1;
      end else if (m_st == 2) begin
        m_pend <= 0;
        if (verify_ok) m_st <= 0;
        else if (m_n == (m_er ? ME : MP)) begin
          m_st <= 0; if (m_er) se = 1; else sp = 1;
        end else if (m_er && (m_pend || suspend_req)) m_st <= 3;
        else m_st <= 1;
      end else if (m_st == 3 && resume_req) m_st <= 1;
      m_ee <= (m_ee && !clear_status) || se;
      m_pe <= (m_pe && !clear_status) || sp;
      m_vl <= (m_vl && !clear_status) || sv;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk("R2", "pulse_on", pulse_on, m_st == 1);
    chk("R4", "ready", ready, m_st == 0 || m_st == 3);
    chk("R9", "susp_flag", susp_flag, m_st == 3);
    chk("R5", "erase_err", erase_err, m_ee);
    chk("R6", "prog_err", prog_err, m_pe);
    chk("R3", "vpp_low", vpp_low, m_vl);
    chk("R10", "op_addr", op_addr, m_addr);
    chk("R13", "pulse_erase", pulse_erase, m_er);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go(input bit erase, input logic [AW-1:0] a, input int nd);
    @(negedge clk);
    need = nd; base = on_cnt; addr_in = a;
    start_erase = erase; start_prog = !erase;
    @(negedge clk);
    start_erase = 0; start_prog = 0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 400 && !(ready && !susp_flag); i++) @(negedge clk);
  endtask

  task automatic wait_susp();
    for (int i = 0; i < 400 && !susp_flag; i++) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clear_status = 1;
    @(negedge clk); clear_status = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "ready", ready, 1);
    chk("R1", "pulse_on", pulse_on, 0);
    chk("R1", "flags", {susp_flag, erase_err, prog_err, vpp_low}, 0);

    // R2 R4 program passing on second pulse
    go(0, 8'h3C, 2);
    chk("R2", "busy after start", ready, 0);
    chk("R2", "op_addr", op_addr, 8'h3C);
    wait_ready();
    chk("R4", "pulse cycles", on_cnt - base, 2 * PW);
    chk("R4", "prog_err", prog_err, 0);

    // R6 program exhausts pulses, R11 sticky then clear
    go(0, 8'h11, 99);
    wait_ready();
    chk("R6", "pulse cycles", on_cnt - base, MP * PW);
    chk("R6", "prog_err", prog_err, 1);
    cyc(5);
    chk("R11", "prog_err sticky", prog_err, 1);
    do_clear();
    chk("R11", "prog_err cleared", prog_err, 0);

    // R3 low supply at start
    vpp_ok = 0;
    go(1, 8'h22, 1);
    vpp_ok = 1;
    chk("R3", "vpp_low", vpp_low, 1);
    chk("R3", "ready", ready, 1);
    cyc(3);
    chk("R3", "no pulse", on_cnt - base, 0);
    do_clear();

    // R7 R8 R10 erase suspended mid pulse then resumed
    go(1, 8'h5A, 4);
    @(negedge clk); suspend_req = 1;
    @(negedge clk); suspend_req = 0;
    wait_susp();
    chk("R7", "susp_flag", susp_flag, 1);
    chk("R7", "pulses at pause", on_cnt - base, PW);
    @(negedge clk); addr_in = 8'hA5; start_prog = 1;
    @(negedge clk); start_prog = 0;
    cyc(4);
    chk("R10", "addr kept", op_addr, 8'h5A);
    chk("R10", "still erase", pulse_erase, 1);
    chk("R7", "no pulse while parked", on_cnt - base, PW);
    @(negedge clk); resume_req = 1;
    @(negedge clk); resume_req = 0;
    chk("R9", "susp cleared on resume", susp_flag, 0);
    wait_ready();
    chk("R8", "total pulses", on_cnt - base, 4 * PW);
    chk("R8", "erase_err", erase_err, 0);

    // R5 R8 failing erase with a pause: limit counts across it
    go(1, 8'h77, 99);
    cyc(PW * 2);
    @(negedge clk); suspend_req = 1;
    @(negedge clk); suspend_req = 0;
    wait_susp();
    cyc(3);
    @(negedge clk); resume_req = 1;
    @(negedge clk); resume_req = 0;
    wait_ready();
    chk("R5", "erase_err", erase_err, 1);
    chk("R8", "pulse total at limit", on_cnt - base, ME * PW);
    do_clear();

    // R12 suspend during program ignored
    go(0, 8'h09, 3);
    @(negedge clk); suspend_req = 1;
    cyc(PW + 2);
    suspend_req = 0;
    wait_ready();
    chk("R12", "no suspend in program", on_cnt - base, 3 * PW);
    suspend_req = 1; cyc(2); suspend_req = 0;
    chk("R12", "idle suspend", susp_flag, 0);

    // R10 start during busy erase ignored
    go(1, 8'h40, 2);
    @(negedge clk); addr_in = 8'h41; start_prog = 1;
    @(negedge clk); start_prog = 0;
    chk("R10", "busy addr", op_addr, 8'h40);
    wait_ready();

    // R13 both starts same cycle
    @(negedge clk);
    need = 1; base = on_cnt; addr_in = 8'h66; start_prog = 1; start_erase = 1;
    @(negedge clk); start_prog = 0; start_erase = 0;
    chk("R13", "program wins", pulse_erase, 0);
    wait_ready();

    cyc(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule